// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer

This block hangs eight timing channels off one free-running counter. Each channel is switched either to input capture or to output compare. In input capture mode the channel watches its pin. A selected transition copies the counter into the channel register and raises the channel's event flag. In output compare mode the channel compares the counter with its register. On a match it raises the flag and drives its pin with a per-channel action: hold, toggle, force low or force high.

Software reaches every control field, channel register and flag through a flat register port. Writes are synchronous and reads are combinational. Two channels, the top one and channel 0, can hand their pins to external pulse accumulators. For each of them the block raises a pass-through enable when the channel is free of timer duties. Each pin also has a drive enable, so that an outside pin mux can take the pin back for general-purpose use when the timer is not driving it.

Top module: `capcmp_timer`

## Requirements
- R1: The counter is 16 bits wide. It resets to 0, advances by one on every clock and wraps from 0xFFFF to 0. Address 0 reads it, and writes to address 0 are ignored.
- R2: After reset every control register, every channel register and every flag reads 0. `pin_out`, `pin_oe` and both pass-through enables are low, and no channel captures.
- R3: Each channel has a 2-bit edge code: 00 disables capture, 01 selects rising edges, 10 falling edges and 11 both. Address 3 holds the codes for channels 7..4 and address 4 holds those for channels 3..0, with the higher channel in the upper bits (channel 7 and channel 3 in bits 7:6). Both registers can be written at any time.
- R4: `pin_in` passes through two synchronizing flops. The value stored on a capture is the counter value visible in the cycle in which the new pin level was first sampled, plus two.
- R5: Capture happens only in input mode. The capture sets the channel flag on the same clock edge that stores the counter. When a capture and a software write to that channel register fall on the same edge, the capture wins.
- R6: A channel in output mode matches when the counter equals its register. On the next clock edge the match sets the flag and applies the action code. Address 2 holds the action codes, with channel n in bits 2n+1:2n: 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. Input-mode channels never change `pin_out`.
- R7: Address 1 holds the mode bits, one per channel: 1 selects input capture and 0 selects output compare. `pin_oe[n]` is high exactly when channel n is in output mode and its action code is not 00.
- R8: Writing address 5 with bit n set clears flag n, and a 0 bit leaves the flag alone. An event on the same edge as a clear leaves the flag set. `evt_flag` shows the flags directly.
- R9: `pacc_a_en` is high exactly when channel 7 is in input mode, its action code is 00 and bit 7 of the mask register (address 6) is clear. `pacc_b_en` uses the same rule with channel 0 and mask bit 0.
- R10: Channel register n is at address 8+n. Writing any of addresses 1..4, 6 and 8..15 is read back unchanged unless a capture intervenes. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| pin_in | input | 8 | Channel pin levels, asynchronous |
| pin_out | output | 8 | Registered channel pin drive values |
| pin_oe | output | 8 | Per-channel drive enables |
| evt_flag | output | 8 | Per-channel event flags |
| pacc_a_en | output | 1 | Channel 7 free for pulse accumulator A |
| pacc_b_en | output | 1 | Channel 0 free for pulse accumulator B |

## Verification
A flaw in the synchronizer depth or in the edge history shows up as a captured value one step off, or as a flag that rises a cycle early or late. The flag port exposes this on the very next edge and a readback exposes it soon after. A counter or compare-register fault moves the cycle in which `pin_out` changes on the output channels, and it persists until the register is rewritten. The bench checks pins, drive enables, flags and pass-through enables on every clock. It also sweeps the read address continuously, so that any bad control or channel state appears at `rd_data` within sixteen cycles.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        EDG_OFF  = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edge_e;

    localparam int A_CNT  = 0;
    localparam int A_MODE = 1;
    localparam int A_ACT  = 2;
    localparam int A_EDGH = 3;
    localparam int A_EDGL = 4;
    localparam int A_FLAG = 5;
    localparam int A_MASK = 6;

endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.s2;
    assign prv = st_q.s3;

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          in_mode,
    input  act_e          act,
    input  edge_e         edg,
    input  logic          sync_lvl,
    input  logic          sync_prev,
    input  logic          wr_reg,
    input  logic [CW-1:0] wr_data,
    input  logic          clr_flag,
    output logic [CW-1:0] reg_val,
    output logic          flag,
    output logic          pin,
    output logic          pin_oe
);

    typedef struct packed {
        logic [CW-1:0] cap;
        logic          flg;
        logic          pin;
    } chan_t;

    chan_t st_d, st_q;
    logic  rise, fall, hit, cap_evt, cmp_evt;

    always_comb begin
        rise = sync_lvl & ~sync_prev;
        fall = ~sync_lvl & sync_prev;
        case (edg)
            EDG_RISE: hit = rise;
            EDG_FALL: hit = fall;
            EDG_ANY:  hit = rise | fall;
            default:  hit = 1'b0;
        endcase
        cap_evt = in_mode & hit;
        cmp_evt = ~in_mode & (cnt == st_q.cap);

        st_d = st_q;
        if (wr_reg)  st_d.cap = wr_data;
        if (cap_evt) st_d.cap = cnt;
        if (clr_flag) st_d.flg = 1'b0;
        if (cap_evt | cmp_evt) st_d.flg = 1'b1;
        if (cmp_evt) begin
            case (act)
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_HIGH:   st_d.pin = 1'b1;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_val = st_q.cap;
    assign flag    = st_q.flg;
    assign pin     = st_q.pin;
    assign pin_oe  = ~in_mode & (act != ACT_OFF);

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (reg_val == $past(cnt)));                               // R4
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || cmp_evt) |=> flag);                                     // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !cap_evt && !cmp_evt) |=> !flag);                      // R8
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode || act == ACT_OFF) |=> $stable(pin));                      // R6
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && act == ACT_TOGGLE) |=> (pin != $past(pin)));            // R6

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    localparam int AW = $clog2(2 * NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [CW-1:0]  rd_data,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] evt_flag,
    output logic           pacc_a_en,
    output logic           pacc_b_en
);

    localparam int TOP = NCH - 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [NCH-1:0]   mode;
        logic [2*NCH-1:0] act;
        logic [2*NCH-1:0] edg;
        logic [NCH-1:0]   mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCH-1:0] s_lvl, s_prv, wr_reg, clr;
    logic [CW-1:0]  reg_val [NCH];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cnt = ctl_q.cnt + CW'(1);
        if (wr_en) begin
            if (wr_addr == AW'(A_MODE)) ctl_d.mode = wr_data[NCH-1:0];
            if (wr_addr == AW'(A_ACT))  ctl_d.act  = wr_data[2*NCH-1:0];
            if (wr_addr == AW'(A_EDGH)) ctl_d.edg[2*NCH-1:NCH] = wr_data[NCH-1:0];
            if (wr_addr == AW'(A_EDGL)) ctl_d.edg[NCH-1:0]     = wr_data[NCH-1:0];
            if (wr_addr == AW'(A_MASK)) ctl_d.mask = wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    capcmp_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .lvl   (s_lvl),
        .prv   (s_prv)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_reg[i] = wr_en && (wr_addr == AW'(NCH + i));
        assign clr[i]    = wr_en && (wr_addr == AW'(A_FLAG)) && wr_data[i];

        capcmp_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (ctl_q.cnt),
            .in_mode   (ctl_q.mode[i]),
            .act       (act_e'(ctl_q.act[2*i +: 2])),
            .edg       (edge_e'(ctl_q.edg[2*i +: 2])),
            .sync_lvl  (s_lvl[i]),
            .sync_prev (s_prv[i]),
            .wr_reg    (wr_reg[i]),
            .wr_data   (wr_data),
            .clr_flag  (clr[i]),
            .reg_val   (reg_val[i]),
            .flag      (evt_flag[i]),
            .pin       (pin_out[i]),
            .pin_oe    (pin_oe[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CNT))  rd_data = ctl_q.cnt;
        if (rd_addr == AW'(A_MODE)) rd_data = CW'(ctl_q.mode);
        if (rd_addr == AW'(A_ACT))  rd_data = CW'(ctl_q.act);
        if (rd_addr == AW'(A_EDGH)) rd_data = CW'(ctl_q.edg[2*NCH-1:NCH]);
        if (rd_addr == AW'(A_EDGL)) rd_data = CW'(ctl_q.edg[NCH-1:0]);
        if (rd_addr == AW'(A_FLAG)) rd_data = CW'(evt_flag);
        if (rd_addr == AW'(A_MASK)) rd_data = CW'(ctl_q.mask);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(NCH + i)) rd_data = reg_val[i];
        end
    end

    assign pacc_a_en = ctl_q.mode[TOP] && (ctl_q.act[2*TOP +: 2] == 2'b00) && !ctl_q.mask[TOP];
    assign pacc_b_en = ctl_q.mode[0]   && (ctl_q.act[1:0] == 2'b00)       && !ctl_q.mask[0];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_q.cnt == $past(ctl_q.cnt) + CW'(1)));                  // R1
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(A_EDGH)) |=> $stable(ctl_q.edg[2*NCH-1:NCH])); // R3
    AST_PACC_A_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pacc_a_en |-> !pin_oe[TOP]);                                         // R9
    AST_PACC_B_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pacc_b_en |-> !pin_oe[0]);                                           // R9

endmodule

// File: tb/capcmp_timer_test.sv
`timescale 1ns/1ps
module capcmp_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, evt_flag;
    logic        pacc_a_en, pacc_b_en;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit sweep_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    capcmp_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .evt_flag(evt_flag), .pacc_a_en(pacc_a_en), .pacc_b_en(pacc_b_en)
    );

    // behavioural reference state
    logic [15:0] m_cnt = '0;
    logic [7:0]  m_mode = '0, m_mask = '0, m_flag = '0, m_pin = '0;
    logic [15:0] m_act = '0, m_edg = '0;
    logic [15:0] m_reg [8];
    logic [7:0]  h1 = '0, h2 = '0, h3 = '0;

    initial for (int n = 0; n < 8; n++) m_reg[n] = '0;

    always @(posedge clk) begin : model
        logic rise, fall, hit, cap, mt;
        if (!rst_n) begin
            m_cnt = '0; m_mode = '0; m_mask = '0; m_flag = '0; m_pin = '0;
            m_act = '0; m_edg = '0; h1 = '0; h2 = '0; h3 = '0;
            for (int n = 0; n < 8; n++) m_reg[n] = '0;
        end else begin
            for (int n = 0; n < 8; n++) begin
                rise = h2[n] && !h3[n];
                fall = !h2[n] && h3[n];
                case (m_edg[2*n +: 2])
                    2'b01:   hit = rise;
                    2'b10:   hit = fall;
                    2'b11:   hit = rise || fall;
                    default: hit = 1'b0;
                endcase
                cap = m_mode[n] && hit;
                mt  = !m_mode[n] && (m_cnt == m_reg[n]);
                if (mt) begin
                    case (m_act[2*n +: 2])
                        2'b01: m_pin[n] = !m_pin[n];
                        2'b10: m_pin[n] = 1'b0;
                        2'b11: m_pin[n] = 1'b1;
                        default: ;
                    endcase
                end
                if (wr_en && wr_addr == 4'(8 + n)) m_reg[n] = wr_data;
                if (cap) m_reg[n] = m_cnt;
                if (wr_en && wr_addr == 4'd5 && wr_data[n]) m_flag[n] = 1'b0;
                if (cap || mt) m_flag[n] = 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd1: m_mode = wr_data[7:0];
                    4'd2: m_act = wr_data;
                    4'd3: m_edg[15:8] = wr_data[7:0];
                    4'd4: m_edg[7:0] = wr_data[7:0];
                    4'd6: m_mask = wr_data[7:0];
                    default: ;
                endcase
            end
            h3 = h2; h2 = h1; h1 = pin_in;
            m_cnt = m_cnt + 16'd1;
        end
    end

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cnt;
            4'd1: return {8'h0, m_mode};
            4'd2: return m_act;
            4'd3: return {8'h0, m_edg[15:8]};
            4'd4: return {8'h0, m_edg[7:0]};
            4'd5: return {8'h0, m_flag};
            4'd6: return {8'h0, m_mask};
            4'd7: return 16'h0;
            default: return m_reg[a - 4'd8];
        endcase
    endfunction

    function automatic logic [7:0] m_oe();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = !m_mode[n] && (m_act[2*n +: 2] != 2'b00);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R6 pin_out", {8'h0, pin_out}, {8'h0, m_pin});
            chk("R7 pin_oe", {8'h0, pin_oe}, {8'h0, m_oe()});
            chk("R5/R8 evt_flag", {8'h0, evt_flag}, {8'h0, m_flag});
            chk("R9 pacc_a_en", {15'h0, pacc_a_en},
                {15'h0, m_mode[7] && m_act[15:14] == 2'b00 && !m_mask[7]});
            chk("R9 pacc_b_en", {15'h0, pacc_b_en},
                {15'h0, m_mode[0] && m_act[1:0] == 2'b00 && !m_mask[0]});
            if (rd_addr == 4'd0)
                chk("R1 counter read", rd_data, m_read(rd_addr));
            else if (rd_addr == 4'd3 || rd_addr == 4'd4)
                chk("R3 edge register read", rd_data, m_read(rd_addr));
            else if (rd_addr >= 4'd8)
                chk("R4/R10 channel register read", rd_data, m_read(rd_addr));
            else
                chk("R10 register read", rd_data, m_read(rd_addr));
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sweep_on) rd_addr = rd_addr + 4'd1;
        end
    end

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_tb();
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_rand(input int cycles, input int hold);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk); #1;
            if (c % hold == 0) pin_in = lfsr[7:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    endtask

    initial begin
        logic [15:0] c0;
        // R2: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a); #1;
            chk("R2 reset read", rd_data, 16'h0);
        end
        chk("R2 reset pins", {pin_out, pin_oe}, 16'h0);
        chk("R2 reset flags/pacc", {6'h0, pacc_a_en, pacc_b_en, evt_flag}, 16'h0);
        rd_addr = '0;
        @(negedge clk); #1 rst_n = 1'b1;
        chk_on = 1'b1;
        sweep_on = 1'b1;
        run_rand(20, 1);

        // mixed modes: ch3..0 capture, ch7..4 compare
        wr(4'd1, 16'h000F);
        wr(4'd4, 16'h00E4);
        wr(4'd2, 16'h6CFF);
        wr(4'd15, 16'd120);
        wr(4'd14, 16'd140);
        wr(4'd13, 16'd160);
        wr(4'd12, 16'd180);
        run_rand(300, 3);
        run_rand(200, 1);
        wr(4'd5, 16'h0000);
        run_rand(5, 50);
        wr(4'd5, 16'h00FF);
        // edge codes on the upper register, written while running
        wr(4'd1, 16'h00F0);
        wr(4'd3, 16'h001B);
        run_rand(200, 2);
        wr(4'd3, 16'h00E4);
        run_rand(200, 5);

        // R4/R5: capture value and collision with a software write
        sweep_on = 1'b0;
        wr(4'd1, 16'h0002);
        wr(4'd4, 16'h0004);
        @(negedge clk); #1 pin_in = 8'h00;
        repeat (4) @(negedge clk);
        #1 pin_in[1] = 1'b1; c0 = m_cnt;
        @(negedge clk);
        @(negedge clk); #1 wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'hDEAD;
        @(negedge clk); #1 wr_en = 1'b0; rd_addr = 4'd9;
        #1 chk("R4/R5 capture value beats write", rd_data, c0 + 16'd2);
        chk("R5 capture flag", {15'h0, evt_flag[1]}, 16'h1);
        sweep_on = 1'b1;

        // R8: clear versus event on the same edge
        wr(4'd1, 16'h0008);
        wr(4'd4, 16'h00C0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            pin_in[3] = !pin_in[3];
            wr_en = 1'b1; wr_addr = 4'd5; wr_data = 16'h0008;
        end
        @(negedge clk); #1 wr_en = 1'b0;
        chk("R8 event wins over clear", {15'h0, evt_flag[3]}, 16'h1);
        repeat (4) @(negedge clk);
        wr(4'd5, 16'h0000);
        chk("R8 zero write keeps flag", {15'h0, evt_flag[3]}, 16'h1);
        wr(4'd5, 16'h0008);
        chk("R8 one write clears flag", {15'h0, evt_flag[3]}, 16'h0);

        // R9: pass-through combinations
        wr(4'd2, 16'h0000);
        wr(4'd6, 16'h0000);
        wr(4'd1, 16'h0081);
        run_rand(4, 1);
        wr(4'd6, 16'h0080);
        run_rand(4, 1);
        wr(4'd2, 16'h0001);
        run_rand(4, 1);
        wr(4'd6, 16'h0001);
        wr(4'd2, 16'h4000);
        run_rand(4, 1);
        wr(4'd1, 16'h0000);
        wr(4'd7, 16'hFFFF);
        wr(4'd0, 16'h1234);
        run_rand(20, 1);

        // R1/R6: counter wrap with compare activity
        wr(4'd2, 16'hE5B1);
        wr(4'd12, 16'h0003);
        wr(4'd8, 16'hFFFF);
        run_rand(65600, 40);

        chk_on = 1'b0;
        finish_tb();
    end

endmodule